// File: doc/BRIEF.md
# Video Bus-Steal Arbiter

This block shares one memory bus between a video fetch engine and an 8-bit CPU that runs on a two-phase clock. Each clock of the block is one CPU cycle. In most cycles the video side uses only the first phase, and the CPU has the second phase. On some cycles the video side also needs the second phase: on every cycle of the 40-slot character-pointer burst of a bad line, and on the two fetch slots of each enabled sprite. On those cycles the arbiter takes the second phase away from the CPU.

The arbiter keeps a cycle-in-line counter and a raster-line counter. Their lengths depend on the region input. It decides at the end of each line whether the next line is a bad line and which sprites it fetches. From that it drives `ba`, which feeds the CPU ready input, and `aec`, which is the second-phase bus-enable level. `ba` falls three cycles ahead of each stolen run. The CPU cannot be halted during a write, and in those three cycles it can finish up to three writes. The block also gives `cpu_halt`, which is the actual stall: `ba` low qualified by a read cycle.

Top module: `vbs_arbiter`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `raster_cyc` and `raster_line` are 0, `ba` and `aec` are 1 and `cpu_halt` is 0. The first line after reset has no fetches.
- R2: `raster_cyc` counts 0 up to N-1 and then wraps to 0, where N is 65 when the latched region is 0 and 63 when it is 1. `raster_line` increments on each wrap.
- R3: A frame has 263 lines for region 0 and 315 lines for region 1. The region input is latched during reset and on the last cycle of the last line of a frame. At all other times it has no effect.
- R4: A line is a bad line when its low three bits equal `yscroll` and it lies within lines 48 to 247 inclusive. `yscroll` and `spr_en` are sampled only on the last cycle of the preceding line.
- R5: On a bad line, `aec` is 0 on cycles 22 through 61, which is 40 cycles.
- R6: When bit i of the sampled `spr_en` is 1, `aec` is 0 on cycles 3+2i and 4+2i of the line.
- R7: `ba` goes to 0 exactly three cycles before the first cycle with `aec` at 0 in each run. It stays 0 through the run and returns to 1 on the cycle after the last stolen cycle. Windows that overlap or touch merge into one low period.
- R8: Outside every window, `ba` and `aec` are both 1. `aec` is never 0 while `ba` is 1.
- R9: `cpu_halt` is 1 exactly when `ba` is 0 and `cpu_rnw` is 1 (a read). A write cycle is never halted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU cycle clock |
| rst | input | 1 | Synchronous active-high reset |
| region | input | 1 | 0 = 65 cycles x 263 lines, 1 = 63 cycles x 315 lines |
| yscroll | input | 3 | Vertical scroll used for bad-line matching |
| spr_en | input | 8 | Per-sprite fetch enable for the next line |
| cpu_rnw | input | 1 | CPU current cycle is a read (1) or write (0) |
| ba | output | 1 | Bus available, drives CPU ready |
| aec | output | 1 | Second-phase address enable, 0 = video owns phase 2 |
| cpu_halt | output | 1 | Effective CPU stall this cycle |
| raster_line | output | 9 | Current raster line |
| raster_cyc | output | 7 | Current cycle within the line |

## Verification
The counters, the `ba` and `aec` levels and the per-line configuration all change at a clock edge. A `yscroll`, `spr_en` or `region` value sampled at an edge therefore shows up only from the next line or the next frame, and the bench's reference model applies it at that same edge. `cpu_halt` is combinational in `cpu_rnw`. The bench drives `cpu_rnw` after the falling edge and compares all five outputs 1 ns later, in the same cycle. The sweep covers a full frame in each region, the region switch at the frame boundary, bad lines, and sprite patterns that include merging with the character window.

// File: rtl/vbs_pkg.sv
package vbs_pkg;

    typedef enum logic {
        RGN_NTSC = 1'b0,
        RGN_PAL  = 1'b1
    } region_e;

    localparam int CYC_W      = 7;
    localparam int LINE_W     = 9;
    localparam int NUM_SPR    = 8;
    localparam int BA_LEAD    = 3;
    localparam int SPR_SLOT0  = 3;
    localparam int CHR_SLOT0  = 22;
    localparam int CHR_SLOTS  = 40;
    localparam int DISP_FIRST = 48;
    localparam int DISP_LAST  = 247;

    typedef logic [CYC_W-1:0]  cyc_t;
    typedef logic [LINE_W-1:0] line_t;

    typedef struct packed {
        logic               bad;
        logic [NUM_SPR-1:0] spr;
    } line_cfg_t;

    function automatic cyc_t cyc_per_line(region_e r);
        return (r == RGN_PAL) ? cyc_t'(63) : cyc_t'(65);
    endfunction

    function automatic line_t lines_per_frame(region_e r);
        return (r == RGN_PAL) ? line_t'(315) : line_t'(263);
    endfunction

    function automatic logic is_bad_line(line_t ln, logic [2:0] ys);
        return (ln[2:0] == ys) && (ln >= line_t'(DISP_FIRST)) && (ln <= line_t'(DISP_LAST));
    endfunction

endpackage

// File: rtl/vbs_raster.sv
module vbs_raster
    import vbs_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  region_e region_in,
    output cyc_t    cyc,
    output line_t   line,
    output logic    eol,
    output logic    eof,
    output region_e region_q
);

    cyc_t  cyc_last;
    line_t line_last;

    always_comb begin
        cyc_last  = cyc_per_line(region_q) - cyc_t'(1);
        line_last = lines_per_frame(region_q) - line_t'(1);
        eol       = (cyc == cyc_last);
        eof       = eol && (line == line_last);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cyc      <= '0;
            line     <= '0;
            region_q <= region_in;
        end else if (eol) begin
            cyc <= '0;
            if (eof) begin
                line     <= '0;
                region_q <= region_in;
            end else begin
                line <= line + line_t'(1);
            end
        end else begin
            cyc <= cyc + cyc_t'(1);
        end
    end

    assert_cyc_bound_R2: assert property (@(posedge clk) disable iff (rst)
        cyc < cyc_per_line(region_q));

    assert_line_bound_R3: assert property (@(posedge clk) disable iff (rst)
        line < lines_per_frame(region_q));

    assert_frame_wrap_R3: assert property (@(posedge clk) disable iff (rst)
        eof |=> (line == '0) && (cyc == '0));

endmodule

// File: rtl/vbs_linecfg.sv
module vbs_linecfg
    import vbs_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               eol,
    input  logic               eof,
    input  line_t              line,
    input  logic [2:0]         yscroll,
    input  logic [NUM_SPR-1:0] spr_en,
    output line_cfg_t          cfg
);

    line_t     next_line;
    line_cfg_t cfg_next;

    always_comb begin
        next_line    = eof ? line_t'(0) : line + line_t'(1);
        cfg_next.bad = is_bad_line(next_line, yscroll);
        cfg_next.spr = spr_en;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg <= '0;
        end else if (eol) begin
            cfg <= cfg_next;
        end
    end

    assert_cfg_hold_R4: assert property (@(posedge clk) disable iff (rst)
        !eol |=> $stable(cfg));

    assert_bad_window_R4: assert property (@(posedge clk) disable iff (rst)
        cfg.bad |-> (line >= line_t'(DISP_FIRST)) && (line <= line_t'(DISP_LAST)));

endmodule

// File: rtl/vbs_window.sv
module vbs_window
    import vbs_pkg::*;
#(
    parameter int N_SPR     = NUM_SPR,
    parameter int LEAD      = BA_LEAD,
    parameter int SPR_FIRST = SPR_SLOT0,
    parameter int CHR_FIRST = CHR_SLOT0,
    parameter int CHR_COUNT = CHR_SLOTS
)(
    input  logic      clk,
    input  logic      rst,
    input  cyc_t      cyc,
    input  line_cfg_t cfg,
    output logic      ba,
    output logic      vid_ph2
);

    localparam int CHR_LAST = CHR_FIRST + CHR_COUNT - 1;
    localparam int CHR_HOLD = CHR_FIRST - LEAD;

    int               c;
    logic [N_SPR-1:0] spr_fetch;
    logic [N_SPR-1:0] spr_hold;
    logic             chr_fetch;
    logic             chr_hold;

    assign c = int'(cyc);

    for (genvar i = 0; i < N_SPR; i++) begin : g_spr
        localparam int SLOT = SPR_FIRST + 2 * i;
        localparam int HOLD = SLOT - LEAD;
        assign spr_fetch[i] = cfg.spr[i] && (c >= SLOT) && (c <= SLOT + 1);
        assign spr_hold[i]  = cfg.spr[i] && (c >= HOLD) && (c <= SLOT + 1);
    end

    assign chr_fetch = cfg.bad && (c >= CHR_FIRST) && (c <= CHR_LAST);
    assign chr_hold  = cfg.bad && (c >= CHR_HOLD)  && (c <= CHR_LAST);

    assign vid_ph2 = (|spr_fetch) || chr_fetch;
    assign ba      = !((|spr_hold) || chr_hold);

    assert_lead_time_R7: assert property (@(posedge clk) disable iff (rst)
        $fell(ba) |-> ##3 vid_ph2);

    assert_lead_low_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(vid_ph2) |-> !$past(ba, 1) && !$past(ba, 2) && !$past(ba, 3));

    assert_release_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(ba) |-> $past(vid_ph2));

    assert_steal_needs_ba_R8: assert property (@(posedge clk) disable iff (rst)
        vid_ph2 |-> !ba);

endmodule

// File: rtl/vbs_arbiter.sv
module vbs_arbiter
    import vbs_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       region,
    input  logic [2:0] yscroll,
    input  logic [7:0] spr_en,
    input  logic       cpu_rnw,
    output logic       ba,
    output logic       aec,
    output logic       cpu_halt,
    output logic [8:0] raster_line,
    output logic [6:0] raster_cyc
);

    cyc_t      cyc;
    line_t     line;
    logic      eol;
    logic      eof;
    region_e   region_q;
    line_cfg_t cfg;
    logic      vid_ph2;

    vbs_raster u_raster (
        .clk       (clk),
        .rst       (rst),
        .region_in (region_e'(region)),
        .cyc       (cyc),
        .line      (line),
        .eol       (eol),
        .eof       (eof),
        .region_q  (region_q)
    );

    vbs_linecfg u_cfg (
        .clk     (clk),
        .rst     (rst),
        .eol     (eol),
        .eof     (eof),
        .line    (line),
        .yscroll (yscroll),
        .spr_en  (spr_en),
        .cfg     (cfg)
    );

    vbs_window u_win (
        .clk     (clk),
        .rst     (rst),
        .cyc     (cyc),
        .cfg     (cfg),
        .ba      (ba),
        .vid_ph2 (vid_ph2)
    );

    assign aec         = !vid_ph2;
    assign cpu_halt    = !ba && cpu_rnw;
    assign raster_line = line;
    assign raster_cyc  = cyc;

    assert_write_not_halted_R9: assert property (@(posedge clk) disable iff (rst)
        !cpu_rnw |-> !cpu_halt);

    assert_halt_under_ba_R9: assert property (@(posedge clk) disable iff (rst)
        cpu_halt |-> !ba);

    always_comb begin
        if (rst) begin
            assert_reset_idle_R1: assert (cfg == '0 || $isunknown(cfg));
        end
    end

endmodule

// File: tb/sim_vbs_arbiter.sv
module sim_vbs_arbiter;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       region = 1'b0;
    logic [2:0] yscroll = 3'd0;
    logic [7:0] spr_en = 8'd0;
    logic       cpu_rnw = 1'b1;
    logic       ba, aec, cpu_halt;
    logic [8:0] raster_line;
    logic [6:0] raster_cyc;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    vbs_arbiter u0 (
        .clk         (clk),
        .rst         (rst),
        .region      (region),
        .yscroll     (yscroll),
        .spr_en      (spr_en),
        .cpu_rnw     (cpu_rnw),
        .ba          (ba),
        .aec         (aec),
        .cpu_halt    (cpu_halt),
        .raster_line (raster_line),
        .raster_cyc  (raster_cyc)
    );

    // Reference state, advanced at each rising edge from the requirements.
    int   m_cyc, m_line;
    bit   m_rgn;
    bit   m_bad;
    bit [7:0] m_spr;
    logic [15:0] lfsr = 16'hACE1;

    function automatic int cpl(bit r);
        return r ? 63 : 65;
    endfunction

    function automatic int lpf(bit r);
        return r ? 315 : 263;
    endfunction

    task automatic check(string tag, int act, int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s line=%0d cyc=%0d actual=%0d expected=%0d",
                     tag, m_line, m_cyc, act, exp);
        end
    endtask

    task automatic compare_all();
        bit vid, hold;
        vid  = m_bad && m_cyc >= 22 && m_cyc <= 61;
        hold = m_bad && m_cyc >= 19 && m_cyc <= 61;
        for (int i = 0; i < 8; i++) begin
            if (m_spr[i] && (m_cyc == 3 + 2 * i || m_cyc == 4 + 2 * i)) vid = 1'b1;
            if (m_spr[i] && m_cyc >= 2 * i && m_cyc <= 4 + 2 * i) hold = 1'b1;
        end
        check("R2 cycle", int'(raster_cyc), m_cyc);
        check("R3 line", int'(raster_line), m_line);
        check("R4 R5 R6 aec", int'(aec), int'(!vid));
        check("R7 R8 ba", int'(ba), int'(!hold));
        check("R9 halt", int'(cpu_halt), int'(hold && cpu_rnw));
    endtask

    task automatic model_edge();
        int nl;
        if (m_cyc == cpl(m_rgn) - 1) begin
            m_cyc = 0;
            nl = (m_line == lpf(m_rgn) - 1) ? 0 : m_line + 1;
            m_bad = (nl % 8 == int'(yscroll)) && nl >= 48 && nl <= 247;
            m_spr = spr_en;
            if (m_line == lpf(m_rgn) - 1) m_rgn = region;
            m_line = nl;
        end else begin
            m_cyc++;
        end
    endtask

    task automatic step_lfsr();
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    endtask

    initial begin
        repeat (3) @(negedge clk);
        #1;
        // R1: state under reset
        check("R1 reset cycle", int'(raster_cyc), 0);
        check("R1 reset line", int'(raster_line), 0);
        check("R1 reset ba", int'(ba), 1);
        check("R1 reset aec", int'(aec), 1);
        check("R1 reset halt", int'(cpu_halt), 0);
        @(negedge clk);
        rst = 1'b0;
        m_cyc = 0; m_line = 0; m_rgn = 1'b0; m_bad = 1'b0; m_spr = 8'd0;
        yscroll = 3'd3;
        for (int k = 0; k < 37300; k++) begin
            step_lfsr();
            cpu_rnw = lfsr[0] | lfsr[3];
            #1;
            compare_all();
            // inputs sampled at the coming edge
            if (k == 100) region = 1'b1;      // R3: takes effect at frame wrap only
            if (k == 17095 + 50) yscroll = 3'd6;
            case (m_line % 16)
                5:       spr_en = 8'hFF;
                9:       spr_en = 8'h80;
                12:      spr_en = 8'h01;
                default: spr_en = lfsr[15:8] & lfsr[7:0];
            endcase
            model_edge();
            @(negedge clk);
        end
        // R3: second frame must be running with 63-cycle lines
        check("R3 region switched", int'(m_rgn), 1);
        done = 1'b1;
    end

    initial begin
        for (int w = 0; w < 150000; w++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule